// File: doc/BRIEF.md
# Instruction-Timed Port I/O Unit

This unit connects a small 4-bit controller core to its pins. The core runs each instruction cycle through eight states (S0 to S7) and raises a flag during the second cycle of a two-cycle instruction. The unit acts on input and output instructions only at one state of that second cycle. During an input instruction it samples the pins of the addressed port at S3. During an output instruction it writes the addressed port's output latch at S4.

The unit serves four ports, and a 5-bit port address selects one of them. Two 4-bit ports (quad A at 04H, quad B at 05H) and one 2-bit port (dual at 08H) each have an output latch and a set of pin inputs. A 1-bit sense input at 0EH can only be read. Inputs have no latch, so a read returns the pin level at the sampling instant and never the latch contents. A read result is held in a register until the next input instruction. The core timing fixes every transfer, so there is no handshake and no back-pressure. An instruction is complete when its second cycle has passed S4.

Top module: `port_io_unit`

## Requirements
- R1: While reset is low and after reset is released, all output latches read as all ones (quad A = 1111, quad B = 1111, dual = 11) and the read data is 0000.
- R2: An output instruction (instr_out high, cyc_second high, cyc_state = 4) to address 04H or 05H loads wdata into quad A or quad B. The latch output shows the new value one clock later.
- R3: An output instruction changes no latch at any state other than 4 or in the first instruction cycle (cyc_second low).
- R4: An output instruction to address 08H stores only wdata[1:0] in the 2-bit dual latch and leaves both quad latches unchanged.
- R5: An input instruction (instr_in high, cyc_second high, cyc_state = 3) to 04H or 05H captures that port's pin levels, not its latch, into rdata one clock later. A pin change at state 4 or later is not seen.
- R6: Reads of the dual port (08H) and the sense input (0EH) return their pins in the low bits, with the unused high bits of rdata equal to 0.
- R7: An input instruction to an address with no port returns 0000. An output instruction to such an address changes no latch.
- R8: rdata holds its value between input instructions, whatever the pins do.
- R9: An output instruction to the sense address (0EH) changes no latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, one state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_state | input | 3 | Current state S0..S7 of the instruction cycle |
| cyc_second | input | 1 | High during the second cycle of a two-cycle instruction |
| instr_in | input | 1 | Current instruction is a port input |
| instr_out | input | 1 | Current instruction is a port output |
| port_addr | input | 5 | Port address 00H..1FH |
| wdata | input | 4 | Data to write on an output instruction |
| rdata | output | 4 | Result of the latest input instruction |
| qa_pins | input | 4 | Pin levels of quad port A |
| qa_latch | output | 4 | Output latch of quad port A |
| qb_pins | input | 4 | Pin levels of quad port B |
| qb_latch | output | 4 | Output latch of quad port B |
| dual_pins | input | 2 | Pin levels of the 2-bit port |
| dual_latch | output | 2 | Output latch of the 2-bit port |
| sense_pin | input | 1 | 1-bit sense input |

## Verification
Every latch drives a pin directly. A latch written at the wrong state or at the wrong address therefore shows a wrong pin value on the clock after the bad edge. A wrong read selection or a wrong sampling state shows up in rdata only after the input instruction's S3 edge, and it stays there until the next read. For this reason the bench moves the pins around S3 and S4 and compares rdata against a behavioural model on every cycle.

// File: rtl/port_io_pkg.sv
package port_io_pkg;

  // Which port an address maps to
  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_QA    = 3'd1,
    SEL_QB    = 3'd2,
    SEL_DUAL  = 3'd3,
    SEL_SENSE = 3'd4
  } port_sel_e;

  localparam int unsigned DEF_ADDR_W   = 5;
  localparam int unsigned DEF_DATA_W   = 4;
  localparam int unsigned DEF_DUAL_W   = 2;
  localparam int unsigned DEF_STATE_W  = 3;
  localparam int unsigned DEF_SAMPLE_S = 3;
  localparam int unsigned DEF_WRITE_S  = 4;
  localparam int unsigned DEF_QA_ADDR    = 5'h04;
  localparam int unsigned DEF_QB_ADDR    = 5'h05;
  localparam int unsigned DEF_DUAL_ADDR  = 5'h08;
  localparam int unsigned DEF_SENSE_ADDR = 5'h0E;

endpackage

// File: rtl/port_io_decode.sv
module port_io_decode
  import port_io_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned QA_ADDR    = DEF_QA_ADDR,
  parameter int unsigned QB_ADDR    = DEF_QB_ADDR,
  parameter int unsigned DUAL_ADDR  = DEF_DUAL_ADDR,
  parameter int unsigned SENSE_ADDR = DEF_SENSE_ADDR
) (
  input  logic [ADDR_W-1:0] addr,
  output port_sel_e         sel
);

  always_comb begin
    if (addr == ADDR_W'(QA_ADDR))           sel = SEL_QA;
    else if (addr == ADDR_W'(QB_ADDR))      sel = SEL_QB;
    else if (addr == ADDR_W'(DUAL_ADDR))    sel = SEL_DUAL;
    else if (addr == ADDR_W'(SENSE_ADDR))   sel = SEL_SENSE;
    else                                    sel = SEL_NONE;
  end

endmodule

// File: rtl/port_io_latch.sv
module port_io_latch #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  // Open-drain style: released (all ones) out of reset
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '1;
    else if (load) q <= d;
  end

endmodule

// File: rtl/port_io_sampler.sv
module port_io_sampler
  import port_io_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned DUAL_W = DEF_DUAL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  port_sel_e         sel,
  input  logic [DATA_W-1:0] qa_pins,
  input  logic [DATA_W-1:0] qb_pins,
  input  logic [DUAL_W-1:0] dual_pins,
  input  logic              sense_pin,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DUAL_PAD  = DATA_W - DUAL_W;
  localparam int unsigned SENSE_PAD = DATA_W - 1;

  logic [DATA_W-1:0] pick;

  always_comb begin
    case (sel)
      SEL_QA:    pick = qa_pins;
      SEL_QB:    pick = qb_pins;
      SEL_DUAL:  pick = {{DUAL_PAD{1'b0}}, dual_pins};
      SEL_SENSE: pick = {{SENSE_PAD{1'b0}}, sense_pin};
      default:   pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    rdata <= '0;
    else if (take) rdata <= pick;
  end

endmodule

// File: rtl/port_io_unit.sv
module port_io_unit
  import port_io_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned DUAL_W     = DEF_DUAL_W,
  parameter int unsigned STATE_W    = DEF_STATE_W,
  parameter int unsigned SAMPLE_S   = DEF_SAMPLE_S,
  parameter int unsigned WRITE_S    = DEF_WRITE_S,
  parameter int unsigned QA_ADDR    = DEF_QA_ADDR,
  parameter int unsigned QB_ADDR    = DEF_QB_ADDR,
  parameter int unsigned DUAL_ADDR  = DEF_DUAL_ADDR,
  parameter int unsigned SENSE_ADDR = DEF_SENSE_ADDR
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] cyc_state,
  input  logic               cyc_second,
  input  logic               instr_in,
  input  logic               instr_out,
  input  logic [ADDR_W-1:0]  port_addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [DATA_W-1:0]  qa_pins,
  output logic [DATA_W-1:0]  qa_latch,
  input  logic [DATA_W-1:0]  qb_pins,
  output logic [DATA_W-1:0]  qb_latch,
  input  logic [DUAL_W-1:0]  dual_pins,
  output logic [DUAL_W-1:0]  dual_latch,
  input  logic               sense_pin
);

  localparam int unsigned NQUAD = 2;

  port_sel_e sel;
  logic      rd_go;
  logic      wr_go;
  logic [NQUAD-1:0]        quad_load;
  logic [NQUAD*DATA_W-1:0] quad_q;

  // Strobes: only in the second cycle, at one fixed state each
  assign rd_go = instr_in  & cyc_second & (cyc_state == STATE_W'(SAMPLE_S));
  assign wr_go = instr_out & cyc_second & (cyc_state == STATE_W'(WRITE_S));

  port_io_decode #(
    .ADDR_W(ADDR_W), .QA_ADDR(QA_ADDR), .QB_ADDR(QB_ADDR),
    .DUAL_ADDR(DUAL_ADDR), .SENSE_ADDR(SENSE_ADDR)
  ) i_decode (
    .addr(port_addr),
    .sel (sel)
  );

  assign quad_load[0] = wr_go & (sel == SEL_QA);
  assign quad_load[1] = wr_go & (sel == SEL_QB);

  for (genvar g = 0; g < NQUAD; g++) begin : g_quad
    port_io_latch #(.WIDTH(DATA_W)) i_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .load (quad_load[g]),
      .d    (wdata),
      .q    (quad_q[g*DATA_W +: DATA_W])
    );
  end

  assign qa_latch = quad_q[0 +: DATA_W];
  assign qb_latch = quad_q[DATA_W +: DATA_W];

  port_io_latch #(.WIDTH(DUAL_W)) i_dual (
    .clk  (clk),
    .rst_n(rst_n),
    .load (wr_go & (sel == SEL_DUAL)),
    .d    (wdata[DUAL_W-1:0]),
    .q    (dual_latch)
  );

  port_io_sampler #(.DATA_W(DATA_W), .DUAL_W(DUAL_W)) i_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (rd_go),
    .sel      (sel),
    .qa_pins  (qa_pins),
    .qb_pins  (qb_pins),
    .dual_pins(dual_pins),
    .sense_pin(sense_pin),
    .rdata    (rdata)
  );

endmodule

// File: rtl/port_io_unit_chk.sv
module port_io_unit_chk
  import port_io_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned DUAL_W     = DEF_DUAL_W,
  parameter int unsigned STATE_W    = DEF_STATE_W,
  parameter int unsigned SAMPLE_S   = DEF_SAMPLE_S,
  parameter int unsigned WRITE_S    = DEF_WRITE_S,
  parameter int unsigned QA_ADDR    = DEF_QA_ADDR,
  parameter int unsigned QB_ADDR    = DEF_QB_ADDR,
  parameter int unsigned DUAL_ADDR  = DEF_DUAL_ADDR,
  parameter int unsigned SENSE_ADDR = DEF_SENSE_ADDR
) (
  input logic               clk,
  input logic               rst_n,
  input logic [STATE_W-1:0] cyc_state,
  input logic               cyc_second,
  input logic               instr_in,
  input logic               instr_out,
  input logic [ADDR_W-1:0]  port_addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [DATA_W-1:0]  rdata,
  input logic [DATA_W-1:0]  qa_pins,
  input logic [DATA_W-1:0]  qa_latch,
  input logic [DATA_W-1:0]  qb_pins,
  input logic [DATA_W-1:0]  qb_latch,
  input logic [DUAL_W-1:0]  dual_pins,
  input logic [DUAL_W-1:0]  dual_latch,
  input logic               sense_pin
);

  logic c_rd, c_wr, at_qa, at_qb, at_dual, at_sense;
  assign c_rd     = instr_in  && cyc_second && cyc_state == STATE_W'(SAMPLE_S);
  assign c_wr     = instr_out && cyc_second && cyc_state == STATE_W'(WRITE_S);
  assign at_qa    = port_addr == ADDR_W'(QA_ADDR);
  assign at_qb    = port_addr == ADDR_W'(QB_ADDR);
  assign at_dual  = port_addr == ADDR_W'(DUAL_ADDR);
  assign at_sense = port_addr == ADDR_W'(SENSE_ADDR);

  // R1
  reset_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (qa_latch == '1 && qb_latch == '1 && dual_latch == '1 && rdata == '0));

  // R2
  qa_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && at_qa) |=> qa_latch == $past(wdata));

  // R2
  qb_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && at_qb) |=> qb_latch == $past(wdata));

  // R3
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c_wr |=> ($stable(qa_latch) && $stable(qb_latch) && $stable(dual_latch)));

  // R4
  dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && at_dual) |=> (dual_latch == $past(wdata[DUAL_W-1:0])
                           && $stable(qa_latch) && $stable(qb_latch)));

  // R5
  qa_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && at_qa) |=> rdata == $past(qa_pins));

  // R5
  qb_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && at_qb) |=> rdata == $past(qb_pins));

  // R6
  dual_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && at_dual) |=> rdata == {{(DATA_W-DUAL_W){1'b0}}, $past(dual_pins)});

  // R6
  sense_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && at_sense) |=> rdata == {{(DATA_W-1){1'b0}}, $past(sense_pin)});

  // R7
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && !at_qa && !at_qb && !at_dual && !at_sense) |=> rdata == '0);

  // R7 R9
  no_port_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && !at_qa && !at_qb && !at_dual)
      |=> ($stable(qa_latch) && $stable(qb_latch) && $stable(dual_latch)));

  // R8
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c_rd |=> $stable(rdata));

endmodule

bind port_io_unit port_io_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DUAL_W(DUAL_W), .STATE_W(STATE_W),
  .SAMPLE_S(SAMPLE_S), .WRITE_S(WRITE_S), .QA_ADDR(QA_ADDR), .QB_ADDR(QB_ADDR),
  .DUAL_ADDR(DUAL_ADDR), .SENSE_ADDR(SENSE_ADDR)
) i_port_io_unit_chk (.*);

// File: tb/test_port_io_unit.sv
`timescale 1ns/1ps
module test_port_io_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cyc_state = '0;
  logic       cyc_second = 1'b0;
  logic       instr_in = 1'b0;
  logic       instr_out = 1'b0;
  logic [4:0] port_addr = '0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic [3:0] qa_pins = 4'h0;
  logic [3:0] qa_latch;
  logic [3:0] qb_pins = 4'h0;
  logic [3:0] qb_latch;
  logic [1:0] dual_pins = 2'b00;
  logic [1:0] dual_latch;
  logic       sense_pin = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  port_io_unit i_port_io_unit (.*);

  // Behavioural reference model, updated at every rising edge
  int m_qa = 15, m_qb = 15, m_dual = 3, m_rd = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_qa = 15; m_qb = 15; m_dual = 3; m_rd = 0;
    end else begin
      if (instr_in && cyc_second && cyc_state == 3) begin
        case (port_addr)
          5'h04:   m_rd = qa_pins;
          5'h05:   m_rd = qb_pins;
          5'h08:   m_rd = dual_pins;
          5'h0E:   m_rd = sense_pin;
          default: m_rd = 0;
        endcase
      end
      if (instr_out && cyc_second && cyc_state == 4) begin
        case (port_addr)
          5'h04:   m_qa = wdata;
          5'h05:   m_qb = wdata;
          5'h08:   m_dual = wdata % 4;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R4 model quad A", qa_latch, m_qa);
      chk("R2 model quad B", qb_latch, m_qb);
      chk("R4 model dual", dual_latch, m_dual);
      chk("R5 R8 model rdata", rdata, m_rd);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      instr_in = 0; instr_out = 0; cyc_second = 0; cyc_state = 3'(i % 8);
    end
  endtask

  // One two-cycle instruction; qa_pins may change at a chosen state of cycle two
  task automatic instr(input bit wr, input bit rd, input logic [4:0] a,
                       input logic [3:0] d, input bit first_only,
                       input int chg_state, input logic [3:0] new_qa);
    for (int c = 0; c < 2; c++) begin
      if (c == 0 || !first_only) begin
        for (int s = 0; s < 8; s++) begin
          @(negedge clk); #1;
          cyc_state = 3'(s); cyc_second = (c == 1);
          instr_out = wr; instr_in = rd; port_addr = a; wdata = d;
          if (c == 1 && s == chg_state) qa_pins = new_qa;
        end
      end
    end
    @(negedge clk); #1;
    instr_in = 0; instr_out = 0; cyc_second = 0; cyc_state = 0;
  endtask

  task automatic wr_port(input logic [4:0] a, input logic [3:0] d);
    instr(1, 0, a, d, 0, -1, 4'h0);
  endtask

  task automatic rd_port(input logic [4:0] a);
    instr(0, 1, a, 4'h0, 0, -1, 4'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 reset quad A", qa_latch, 15);
    chk("R1 reset quad B", qb_latch, 15);
    chk("R1 reset dual", dual_latch, 3);
    chk("R1 reset rdata", rdata, 0);
    #1 rst_n = 1;
    idle(4);
    @(negedge clk);
    chk("R1 after reset quad A", qa_latch, 15);
    chk("R1 after reset rdata", rdata, 0);

    // R2 writes to both quad ports
    wr_port(5'h04, 4'h5);
    @(negedge clk); chk("R2 quad A write", qa_latch, 5);
    wr_port(5'h05, 4'hA);
    @(negedge clk); chk("R2 quad B write", qb_latch, 10);

    // R3 first cycle only: no write
    instr(1, 0, 5'h04, 4'h0, 1, -1, 4'h0);
    @(negedge clk); chk("R3 first cycle write ignored", qa_latch, 5);

    // R4 dual keeps the low two bits, quads untouched
    wr_port(5'h08, 4'hE);
    @(negedge clk);
    chk("R4 dual low bits", dual_latch, 2);
    chk("R4 quad A untouched", qa_latch, 5);
    chk("R4 quad B untouched", qb_latch, 10);

    // R5 read returns the pins, not the latch
    qa_pins = 4'hC;
    rd_port(5'h04);
    @(negedge clk); chk("R5 quad A pin level", rdata, 12);
    qb_pins = 4'h3;
    rd_port(5'h05);
    @(negedge clk); chk("R5 quad B pin level", rdata, 3);

    // R5 pin change at S4 is too late, at S3 is seen
    qa_pins = 4'h6;
    instr(0, 1, 5'h04, 4'h0, 0, 4, 4'h9);
    @(negedge clk); chk("R5 change at S4 not seen", rdata, 6);
    qa_pins = 4'h1;
    instr(0, 1, 5'h04, 4'h0, 0, 3, 4'hB);
    @(negedge clk); chk("R5 change at S3 seen", rdata, 11);

    // R8 rdata holds while pins move
    qa_pins = 4'h0; qb_pins = 4'hF;
    idle(10);
    @(negedge clk); chk("R8 rdata held", rdata, 11);

    // R6 narrow reads zero-extended
    dual_pins = 2'b11;
    rd_port(5'h08);
    @(negedge clk); chk("R6 dual read", rdata, 3);
    sense_pin = 1'b1;
    rd_port(5'h0E);
    @(negedge clk); chk("R6 sense read", rdata, 1);

    // R7 unmapped read and write
    qa_pins = 4'hF;
    rd_port(5'h04);
    rd_port(5'h1F);
    @(negedge clk); chk("R7 unmapped read", rdata, 0);
    wr_port(5'h1F, 4'h0);
    @(negedge clk);
    chk("R7 unmapped write quad A", qa_latch, 5);
    chk("R7 unmapped write quad B", qb_latch, 10);
    chk("R7 unmapped write dual", dual_latch, 2);

    // R9 write to sense address changes nothing
    wr_port(5'h0E, 4'h0);
    @(negedge clk);
    chk("R9 sense write quad A", qa_latch, 5);
    chk("R9 sense write dual", dual_latch, 2);

    idle(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule